// File: doc/BRIEF.md
# Single-Channel Request-Driven DMA Mover

This block is one DMA channel. Each time the selected request line rises, it copies one unit of data between a memory location and a fixed peripheral location. A unit is one byte or one 16-bit word. Software sets up four registers through a write-only port: a memory pointer, a peripheral pointer, a unit count and a control word. The control word selects one of seven request sources, the unit size, whether the memory pointer counts up or down, whether the pointers move at all, whether the end interrupt is enabled, and whether the channel is armed.

Software never chooses the direction of a copy. The source code decides it. When the serial-receive-full source or the converter-done source is selected, the channel reads from the peripheral pointer and writes to the memory pointer. Every other source reads from memory and writes to the peripheral. Each unit takes one read beat and then one write beat on a single-beat master port. The data passes through a holding register between the two beats. When the count runs out, the channel disarms itself and sets a sticky end flag. The flag drives the interrupt output when the interrupt is enabled.

The controller has three states. `ST_IDLE` waits for an armed channel with a pending request. It moves to `ST_READ` when it accepts that request. `ST_READ` issues the read beat and moves to `ST_WRITE` on acknowledge, capturing the data. `ST_WRITE` issues the write beat. On acknowledge it returns to `ST_IDLE` and updates the pointer and the count.

Top module: `dma_chan`

## Requirements
- R1: After reset, `bus_req` and `irq` are low and the channel is disarmed. A request pulse before any register write causes no bus activity.
- R2: Control bits [2:0] select the request source. The codes are: 0, 1, 2 for timer channels 0 to 2; 3 for serial transmit-empty; 4 for serial receive-full; 5 for converter-done; 6 for the external line. Each code c maps to `req_in[c]`. Code 7 selects nothing. Only a rising edge of the selected line counts, so other lines and a line held high start nothing more.
- R3: Source codes 4 and 5 read from the peripheral pointer and write to the memory pointer. All other codes read from the memory pointer and write to the peripheral pointer.
- R4: Each accepted request makes exactly one read beat followed by one write beat. Control bit 6 sets the size. With 0, `bus_word` is 0 and only data bits [7:0] are meaningful. With 1, `bus_word` is 1 and all 16 bits move.
- R5: With control bit 4 at 0 (pointer-stepping mode), the memory pointer moves after every unit by 1 for bytes or 2 for words. It moves upward when control bit 5 is 0 and downward when it is 1. The peripheral pointer never changes.
- R6: With control bit 4 at 1 (fixed mode), neither pointer changes between units.
- R7: After the number of units written to the count register (offset 2), the channel clears its arm bit, and later requests are ignored. A count of 0 means 2^CW units.
- R8: Finishing the last unit sets the end flag (control bit 8). `irq` equals the end flag ANDed with control bit 3. A control write with bit 8 at 0 clears the flag. Writing 1 to bit 8 cannot set it.
- R9: While control bit 7 (arm) is 0, edges on the selected line are neither served nor remembered for later.
- R10: An edge that arrives while a unit is in flight is held pending and served next. Several edges during one unit merge into a single pending request.
- R11: Once `bus_req` is raised, it stays high with a stable address and write flag until `bus_ack`.
- R12: Register offsets on `reg_addr` are: 0 for the memory pointer, 1 for the peripheral pointer, 2 for the count and 3 for the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | RW | Register write data |
| req_in | input | 7 | Request lines, one per source code |
| bus_req | output | 1 | Bus beat request |
| bus_we | output | 1 | 1 for a write beat, 0 for a read beat |
| bus_word | output | 1 | 1 for a 16-bit beat, 0 for a byte beat |
| bus_addr | output | AW | Beat address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, captured on acknowledge |
| bus_ack | input | 1 | Beat acknowledge |
| irq | output | 1 | End-of-count interrupt |

## Verification
The embedded properties check these rules on every cycle:
- the bus request stays stable until acknowledged;
- every acknowledged read is followed directly by a write;
- the peripheral pointer stays still across units, and the memory pointer does too in fixed mode;
- the last unit disarms the channel and sets the end flag;
- a disarmed idle channel stays off the bus;
- the interrupt rises only after a completed unit or a register write.

Only the bench scenarios can show the rest:
- the direction chosen for each of the seven source codes;
- the exact pointer sequence for each size and stepping direction;
- the total number of units moved;
- edges being dropped while disarmed, merged while busy, or ignored on unselected lines.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    // number of request lines and width of the select field
    localparam int NSRC = 7;
    localparam int SRCW = 3;

    // source codes whose copies run peripheral -> memory
    localparam logic [SRCW-1:0] SRC_RXFULL  = 3'd4;
    localparam logic [SRCW-1:0] SRC_CONVEND = 3'd5;

    // register offsets
    localparam logic [1:0] RO_MEM  = 2'd0;
    localparam logic [1:0] RO_PER  = 2'd1;
    localparam logic [1:0] RO_CNT  = 2'd2;
    localparam logic [1:0] RO_CTRL = 2'd3;

    // control word bit positions
    localparam int CB_SRC   = 0;
    localparam int CB_IE    = 3;
    localparam int CB_FIXED = 4;
    localparam int CB_DOWN  = 5;
    localparam int CB_WORD  = 6;
    localparam int CB_ARM   = 7;
    localparam int CB_END   = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } dma_state_e;

    typedef struct packed {
        logic [SRCW-1:0] src;
        logic            ie;
        logic            fixed;
        logic            down;
        logic            word;
        logic            arm;
        logic            endf;
    } ctrl_t;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_chan_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int RW = 16,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [1:0]      reg_addr,
    input  logic [RW-1:0]   reg_wdata,
    input  logic            xfer_done,
    output logic [AW-1:0]   mem_ptr,
    output logic [AW-1:0]   per_ptr,
    output logic [SRCW-1:0] src,
    output logic            ie,
    output logic            arm,
    output logic            word,
    output logic            endf,
    output logic            last
);

    localparam int WSTEP = DW / 8;

    ctrl_t          ctrl;
    logic [CW-1:0]  count;
    logic [AW-1:0]  step;
    logic           wr_mem, wr_per, wr_cnt, wr_ctl;

    assign wr_mem = reg_we && (reg_addr == RO_MEM);
    assign wr_per = reg_we && (reg_addr == RO_PER);
    assign wr_cnt = reg_we && (reg_addr == RO_CNT);
    assign wr_ctl = reg_we && (reg_addr == RO_CTRL);

    assign step = ctrl.word ? AW'(WSTEP) : AW'(1);
    assign last = (count == CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ptr <= '0;
            per_ptr <= '0;
            count   <= '0;
            ctrl    <= '0;
        end else begin
            if (xfer_done) begin
                if (!ctrl.fixed) begin
                    mem_ptr <= ctrl.down ? (mem_ptr - step) : (mem_ptr + step);
                end
                count <= count - CW'(1);
                if (last) begin
                    ctrl.arm  <= 1'b0;
                    ctrl.endf <= 1'b1;
                end
            end
            if (wr_mem) mem_ptr <= reg_wdata[AW-1:0];
            if (wr_per) per_ptr <= reg_wdata[AW-1:0];
            if (wr_cnt) count   <= reg_wdata[CW-1:0];
            if (wr_ctl) begin
                ctrl.src   <= reg_wdata[CB_SRC +: SRCW];
                ctrl.ie    <= reg_wdata[CB_IE];
                ctrl.fixed <= reg_wdata[CB_FIXED];
                ctrl.down  <= reg_wdata[CB_DOWN];
                ctrl.word  <= reg_wdata[CB_WORD];
                ctrl.arm   <= reg_wdata[CB_ARM];
                ctrl.endf  <= ctrl.endf & reg_wdata[CB_END];
            end
        end
    end

    assign src  = ctrl.src;
    assign ie   = ctrl.ie;
    assign arm  = ctrl.arm;
    assign word = ctrl.word;
    assign endf = ctrl.endf;

    // R7
    last_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && last && !wr_ctl) |=> (!ctrl.arm && ctrl.endf));

    // R5
    per_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !wr_per) |=> $stable(per_ptr));

    // R6
    fixed_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && ctrl.fixed && !wr_mem) |=> $stable(mem_ptr));

endmodule

// File: rtl/dma_req_det.sv
module dma_req_det
    import dma_chan_pkg::*;
#(
    parameter int NS = NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NS-1:0]   req_in,
    input  logic [SRCW-1:0] src,
    input  logic            arm,
    input  logic            take,
    output logic            pending
);

    localparam int NSLOT = 1 << SRCW;

    logic [NS-1:0]    prev;
    logic [NSLOT-1:0] rise_all;
    logic             sel_rise;

    always_comb begin
        rise_all         = '0;
        rise_all[NS-1:0] = req_in & ~prev;
    end

    assign sel_rise = rise_all[src];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev    <= '0;
            pending <= 1'b0;
        end else begin
            prev <= req_in;
            if (!arm)          pending <= 1'b0;
            else if (sel_rise) pending <= 1'b1;
            else if (take)     pending <= 1'b0;
        end
    end

    // R9
    arm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(arm));

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import dma_chan_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic [SRCW-1:0] src,
    input  logic            word,
    input  logic            pending,
    input  logic [AW-1:0]   mem_ptr,
    input  logic [AW-1:0]   per_ptr,
    input  logic            bus_ack,
    input  logic [DW-1:0]   bus_rdata,
    output logic            take,
    output logic            xfer_done,
    output logic            bus_req,
    output logic            bus_we,
    output logic            bus_word,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata
);

    dma_state_e    state, nxt;
    logic          to_mem;
    logic [DW-1:0] hold;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (arm && pending) nxt = ST_READ;
            ST_READ:  if (bus_ack)        nxt = ST_WRITE;
            ST_WRITE: if (bus_ack)        nxt = ST_IDLE;
            default:                      nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        take      = 1'b0;
        xfer_done = 1'b0;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = mem_ptr;
        unique case (state)
            ST_IDLE: take = arm && pending;
            ST_READ: begin
                bus_req  = 1'b1;
                bus_addr = to_mem ? per_ptr : mem_ptr;
            end
            ST_WRITE: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = to_mem ? mem_ptr : per_ptr;
                xfer_done = bus_ack;
            end
            default: ;
        endcase
    end

    assign bus_word  = word;
    assign bus_wdata = word ? hold : {{(DW-8){1'b0}}, hold[7:0]};

    // direction latch and data holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_mem <= 1'b0;
            hold   <= '0;
        end else begin
            if (take) to_mem <= (src == SRC_RXFULL) || (src == SRC_CONVEND);
            if (state == ST_READ && bus_ack) hold <= bus_rdata;
        end
    end

    // R11
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    // R4
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && !bus_we) |=> (bus_req && bus_we));

    // R9
    disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !arm) |=> !bus_req);

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int RW = 16,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [1:0]      reg_addr,
    input  logic [RW-1:0]   reg_wdata,
    input  logic [NSRC-1:0] req_in,
    output logic            bus_req,
    output logic            bus_we,
    output logic            bus_word,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    input  logic [DW-1:0]   bus_rdata,
    input  logic            bus_ack,
    output logic            irq
);

    logic [AW-1:0]   mem_ptr, per_ptr;
    logic [SRCW-1:0] src;
    logic            ie, arm, word, endf, last;
    logic            pending, take, xfer_done;

    dma_regs #(.AW(AW), .CW(CW), .RW(RW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .xfer_done (xfer_done),
        .mem_ptr   (mem_ptr),
        .per_ptr   (per_ptr),
        .src       (src),
        .ie        (ie),
        .arm       (arm),
        .word      (word),
        .endf      (endf),
        .last      (last)
    );

    dma_req_det #(.NS(NSRC)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_in  (req_in),
        .src     (src),
        .arm     (arm),
        .take    (take),
        .pending (pending)
    );

    dma_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .src       (src),
        .word      (word),
        .pending   (pending),
        .mem_ptr   (mem_ptr),
        .per_ptr   (per_ptr),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .take      (take),
        .xfer_done (xfer_done),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    assign irq = endf & ie;

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(xfer_done) || $past(reg_we)));

    // R7
    last_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && last) |=> !bus_req);

endmodule

// File: tb/dma_chan_tb.sv
`timescale 1ns/1ps
module dma_chan_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [6:0]  req_in = '0;
    logic        bus_req, bus_we, bus_word, irq;
    logic [15:0] bus_addr, bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    logic        lg_we   [64];
    logic        lg_word [64];
    logic [15:0] lg_addr [64];
    logic [15:0] lg_data [64];
    int          lg_n = 0;

    always #4 clk = ~clk;

    dma_chan u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .req_in(req_in), .bus_req(bus_req),
        .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .irq(irq)
    );

    // bus responder: log each beat once, acknowledge one cycle later
    always @(negedge clk) begin
        if (bus_req && !bus_ack) begin
            if (lg_n < 64) begin
                lg_we[lg_n]   = bus_we;
                lg_word[lg_n] = bus_word;
                lg_addr[lg_n] = bus_addr;
                lg_data[lg_n] = bus_wdata;
            end
            lg_n = lg_n + 1;
            bus_ack   <= 1'b1;
            bus_rdata <= {~bus_addr[7:0], bus_addr[7:0]};
        end else begin
            bus_ack <= 1'b0;
        end
    end

    function automatic logic [15:0] rd_val(input logic [15:0] a);
        return {~a[7:0], a[7:0]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [15:0] cw(input int src, input bit ie, input bit fixed,
                                       input bit down, input bit word, input bit arm);
        return 16'(src) | (16'(ie) << 3) | (16'(fixed) << 4) | (16'(down) << 5)
             | (16'(word) << 6) | (16'(arm) << 7);
    endfunction

    task automatic pulse(input int i);
        @(negedge clk); req_in[i] = 1'b1;
        repeat (2) @(negedge clk);
        req_in[i] = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // check one logged beat: {we, word, addr, data masked}
    task automatic chk_beat(input string tag, input int idx, input bit we, input bit word,
                            input logic [15:0] addr, input logic [15:0] data);
        logic [15:0] m;
        m = word ? 16'hFFFF : 16'h00FF;
        if (!we) m = 16'h0000;
        chk(tag, {30'd0, lg_we[idx], lg_word[idx], lg_addr[idx], lg_data[idx] & m},
                 {30'd0, we, word, addr, data & m});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base;
        logic [15:0] m, pa, a;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 bus_req in reset", 64'(bus_req), 64'd0);
        chk("R1 irq in reset", 64'(irq), 64'd0);
        rst_n = 1'b1;
        base = lg_n;
        pulse(6);
        chk("R1 no activity unarmed", 64'(lg_n - base), 64'd0);

        // R2 R3 R4 R5 R8 R12: sweep every source, byte, upward, count 2
        for (int s = 0; s < 7; s++) begin
            bit tm;
            tm = (s == 4) || (s == 5);
            m  = 16'h0020 + 16'(s * 8);
            pa = 16'h0080;
            wr(2'd0, m);
            wr(2'd1, pa);
            wr(2'd2, 16'd2);
            wr(2'd3, cw(s, 1, 0, 0, 0, 1));
            base = lg_n;
            pulse(s);
            pulse(s);
            chk($sformatf("R4 beats src%0d", s), 64'(lg_n - base), 64'd4);
            for (int t = 0; t < 2; t++) begin
                a = m + 16'(t);
                if (tm) begin
                    chk_beat($sformatf("R3 rd src%0d", s), base + 2*t,     0, 0, pa, 16'h0);
                    chk_beat($sformatf("R5 wr src%0d", s), base + 2*t + 1, 1, 0, a, rd_val(pa));
                end else begin
                    chk_beat($sformatf("R5 rd src%0d", s), base + 2*t,     0, 0, a, 16'h0);
                    chk_beat($sformatf("R3 wr src%0d", s), base + 2*t + 1, 1, 0, pa, rd_val(a));
                end
            end
            chk($sformatf("R8 irq set src%0d", s), 64'(irq), 64'd1);
            wr(2'd3, cw(s, 1, 0, 0, 0, 0));
            chk($sformatf("R8 irq cleared src%0d", s), 64'(irq), 64'd0);
        end

        // R4 R5 R8: word, downward, count 3, interrupt disabled
        m = 16'h1000; pa = 16'h0090;
        wr(2'd0, m); wr(2'd1, pa); wr(2'd2, 16'd3);
        wr(2'd3, cw(6, 0, 0, 1, 1, 1));
        base = lg_n;
        for (int t = 0; t < 3; t++) pulse(6);
        chk("R4 word beats", 64'(lg_n - base), 64'd6);
        for (int t = 0; t < 3; t++) begin
            a = m - 16'(2 * t);
            chk_beat("R5 word rd down", base + 2*t,     0, 1, a, 16'h0);
            chk_beat("R4 word wr",      base + 2*t + 1, 1, 1, pa, rd_val(a));
        end
        chk("R8 irq masked", 64'(irq), 64'd0);
        // R7: disarmed after count runs out
        base = lg_n;
        pulse(6);
        chk("R7 ignored after end", 64'(lg_n - base), 64'd0);

        // R6: fixed mode, receive-full source, count 3
        m = 16'h0300; pa = 16'h00A0;
        wr(2'd0, m); wr(2'd1, pa); wr(2'd2, 16'd3);
        wr(2'd3, cw(4, 1, 1, 0, 0, 1));
        base = lg_n;
        for (int t = 0; t < 3; t++) pulse(4);
        chk("R6 beats", 64'(lg_n - base), 64'd6);
        for (int t = 0; t < 3; t++) begin
            chk_beat("R6 rd fixed", base + 2*t,     0, 0, pa, 16'h0);
            chk_beat("R6 wr fixed", base + 2*t + 1, 1, 0, m, rd_val(pa));
        end
        wr(2'd3, 16'h0000);

        // R9: edges while disarmed are not served and not remembered
        wr(2'd0, 16'h0400); wr(2'd1, 16'h0050); wr(2'd2, 16'd1);
        wr(2'd3, cw(6, 1, 0, 0, 0, 0));
        base = lg_n;
        pulse(6);
        wr(2'd3, cw(6, 1, 0, 0, 0, 1));
        repeat (10) @(negedge clk);
        chk("R9 dropped while disarmed", 64'(lg_n - base), 64'd0);
        pulse(6);
        chk("R9 served once armed", 64'(lg_n - base), 64'd2);
        wr(2'd3, 16'h0000);

        // R2: unselected lines and code 7
        wr(2'd2, 16'd1);
        wr(2'd3, cw(0, 0, 0, 0, 0, 1));
        base = lg_n;
        pulse(1); pulse(2); pulse(6);
        chk("R2 unselected ignored", 64'(lg_n - base), 64'd0);
        wr(2'd3, cw(7, 0, 0, 0, 0, 1));
        for (int i = 0; i < 7; i++) pulse(i);
        chk("R2 code 7 selects none", 64'(lg_n - base), 64'd0);

        // R2: level held high serves once
        wr(2'd2, 16'd2);
        wr(2'd3, cw(0, 0, 0, 0, 0, 1));
        base = lg_n;
        @(negedge clk); req_in[0] = 1'b1;
        repeat (30) @(negedge clk);
        chk("R2 held level one unit", 64'(lg_n - base), 64'd2);
        req_in[0] = 1'b0;
        pulse(0);
        chk("R2 next edge served", 64'(lg_n - base), 64'd4);

        // R10: three quick edges during one unit give two units
        wr(2'd2, 16'd3);
        wr(2'd3, cw(6, 1, 0, 0, 0, 1));
        base = lg_n;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); req_in[6] = 1'b1;
            @(negedge clk); req_in[6] = 1'b0;
        end
        repeat (20) @(negedge clk);
        chk("R10 pending merged", 64'(lg_n - base), 64'd4);
        chk("R10 count not done", 64'(irq), 64'd0);
        pulse(6);
        chk("R10 third unit", 64'(lg_n - base), 64'd6);
        chk("R8 irq after third", 64'(irq), 64'd1);
        // R8: writing 1 to the end bit keeps it, writing 0 clears it
        wr(2'd3, cw(6, 1, 0, 0, 0, 0) | 16'h0100);
        chk("R8 flag kept", 64'(irq), 64'd1);
        wr(2'd3, cw(6, 1, 0, 0, 0, 0));
        chk("R8 flag cleared", 64'(irq), 64'd0);
        wr(2'd3, cw(6, 1, 0, 0, 0, 0) | 16'h0100);
        chk("R8 flag not settable", 64'(irq), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule